// File: doc/BRIEF.md
# Alternating-Sign Weight Encoder and Pair-Result Recombiner

This block holds the digital ends of a compute-in-memory column pair scheme. Each stored weight bit carries its own sign: the four bits of a code, from MSB to LSB, are worth -8, +4, -2 and +1. The two bits of a pair therefore have opposite signs, and one differential converter can measure both columns of the pair. The range of such a code is lopsided (-10 to +5), so every weight is shifted down by a constant bias of 2 before it is encoded. The encoder takes a signed weight, subtracts the bias, and produces the four-bit code one cycle later. It raises an error flag when the weight falls outside the range the code can hold.

The recombiner sits after the converters. It takes the digitized signed result of each bit pair, lower pair first, and combines them by shift-and-add, with the upper pair worth four times the lower. It then adds back twice the activation sum, which a shared column storing all ones supplies. The result is the plain signed dot product of the activations and the original weights. A ternary mode turns the scheme off: one pair result then passes straight to the output, with no shift and no bias term.

Top module: `asw_codec_top`

## Requirements
- R1: For a weight w in -8..7, enc_code (bit 3 down to bit 0, worth -8, +4, -2, +1) satisfies -8*b3 + 4*b2 - 2*b1 + b0 = w - 2.
- R2: For a 5-bit signed weight outside -8..7, enc_err is 1 and enc_code is 0000. Inside that range enc_err is 0.
- R3: enc_out_valid, enc_code and enc_err are registered. They reflect the weight presented with enc_in_valid one cycle earlier, and enc_out_valid is 0 in any cycle after one without enc_in_valid.
- R4: In normal mode (ternary_mode = 0 on the first beat), two accepted pair beats p_lo then p_hi give res_data = p_lo + 4*p_hi + 2*act_sum.
- R5: act_sum is sampled only on the beat that completes a group. Its value on any other beat has no effect on res_data.
- R6: ternary_mode is sampled only on the first beat of a group. When it is 1, that beat completes alone and res_data equals pair_data sign-extended, with no bias. On the upper beat of a normal group, ternary_mode is ignored.
- R7: res_valid is a single-cycle pulse, asserted one cycle after each group-completing beat and at no other time. Idle cycles between the beats of a group do not disturb it.
- R8: res_data is wide enough that the extreme inputs give exact results: 127, 127 with act_sum 1023 gives 2681; -128, -128 with act_sum 0 gives -640.
- R9: A synchronous active-high rst clears res_valid, res_data and enc_out_valid, and drops any partly received group, so the next beat is taken as a lower pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in_valid | input | 1 | Weight present for encoding |
| enc_weight | input | 5 | Signed weight to encode |
| enc_out_valid | output | 1 | Encoded code valid |
| enc_code | output | 4 | Alternating-sign code, bit 3 worth -8 |
| enc_err | output | 1 | Weight not representable |
| pair_valid | input | 1 | Pair result beat present |
| pair_data | input | 8 | Signed digitized pair result |
| act_sum | input | 10 | Unsigned activation sum from the all-ones column |
| ternary_mode | input | 1 | Encoding bypass, sampled at group start |
| res_valid | output | 1 | Result valid pulse |
| res_data | output | 14 | Signed dot-product result |

## Verification
The in-line properties check on every cycle that the registered code decodes back to the presented weight minus the bias and that error codes are zeroed. They also check that output valids follow their inputs by exactly one cycle, that the pair index never exceeds the last pair, and that a ternary beat reaches the output unchanged. Only the bench's scenarios can show that the full chain gives the true dot product: it builds column sums from its own encodings of weight and activation vectors and compares against a directly computed sum of products. The same scenarios cover the extreme values, the act_sum and mode inputs being ignored on the wrong beat, gaps between beats, and a reset in the middle of a group.

// File: rtl/asw_pkg.sv
package asw_pkg;

  // Two-bit pair digit: bit1 is the negative (x2) bit, bit0 the positive bit.
  function automatic logic [1:0] pair_bits(input int digit);
    logic [1:0] b;
    b[1] = (digit < 0);
    b[0] = ((digit & 1) != 0);
    return b;
  endfunction

  // Value of an alternating-sign code of npair pairs (used by checks).
  function automatic int code_value(input logic [15:0] code, input int npair);
    int v;
    int scale;
    v = 0;
    scale = 1;
    for (int k = 0; k < npair; k++) begin
      v = v + scale * (int'(code[2*k]) - 2 * int'(code[2*k+1]));
      scale = scale * 4;
    end
    return v;
  endfunction

endpackage

// File: rtl/asw_encoder.sv
module asw_encoder #(
  parameter int WIN_W = 5,
  parameter int NPAIR = 2,
  parameter int BIAS  = 2,
  localparam int CODE_W = 2 * NPAIR
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [WIN_W-1:0]  weight,
  output logic                     out_valid,
  output logic [CODE_W-1:0]        code,
  output logic                     err
);
  import asw_pkg::*;

  localparam int S_MAX = ((1 << CODE_W) - 1) / 3;
  localparam int S_MIN = -2 * S_MAX;
  localparam int W_MIN = S_MIN + BIAS;
  localparam int W_MAX = S_MAX + BIAS;

  logic [CODE_W-1:0] code_c;
  logic              bad_c;
  int                rem_c;
  int                dig_c;

  always_comb begin
    rem_c  = int'(weight) - BIAS;
    dig_c  = 0;
    code_c = '0;
    for (int k = 0; k < NPAIR; k++) begin
      dig_c = ((rem_c + 2) & 3) - 2;
      code_c[2*k +: 2] = pair_bits(dig_c);
      rem_c = (rem_c - dig_c) >>> 2;
    end
    bad_c = (int'(weight) < W_MIN) || (int'(weight) > W_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      code      <= '0;
      err       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      code      <= (in_valid && !bad_c) ? code_c : '0;
      err       <= in_valid && bad_c;
    end
  end

  a_r3_enc_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r3_enc_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r2_err_zero_code: assert property (@(posedge clk) disable iff (rst)
    err |-> (code == '0) && out_valid);
  a_r1_code_decodes: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !err) |-> (code_value(16'(code), NPAIR) + BIAS == $past(int'(weight))));

endmodule

// File: rtl/asw_pair_acc.sv
module asw_pair_acc #(
  parameter int PAIR_W = 8,
  parameter int NPAIR  = 2,
  parameter int SUM_W  = 11,
  localparam int IDX_W = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pair_valid,
  input  logic signed [PAIR_W-1:0] pair_data,
  input  logic                     ternary_mode,
  output logic                     done,
  output logic                     tern,
  output logic signed [SUM_W-1:0]  sum
);
  logic [IDX_W-1:0]        idx;
  logic signed [SUM_W-1:0] acc;
  logic signed [SUM_W-1:0] pair_ext;
  logic signed [SUM_W-1:0] term_c;
  logic                    start_c;
  logic                    last_c;

  assign pair_ext = SUM_W'(pair_data);
  assign start_c  = (idx == '0);
  assign tern     = start_c && ternary_mode;
  assign last_c   = tern || (idx == IDX_W'(NPAIR - 1));
  assign term_c   = pair_ext <<< (2 * idx);
  assign sum      = (start_c ? '0 : acc) + term_c;
  assign done     = pair_valid && last_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      acc <= '0;
    end else if (pair_valid) begin
      idx <= last_c ? '0 : idx + 1'b1;
      acc <= sum;
    end
  end

  a_r4_idx_bound: assert property (@(posedge clk) disable iff (rst)
    int'(idx) <= NPAIR - 1);
  a_r4_group_restart: assert property (@(posedge clk) disable iff (rst)
    done |=> (idx == '0));
  a_r7_idle_holds_idx: assert property (@(posedge clk) disable iff (rst)
    !pair_valid |=> $stable(idx));

endmodule

// File: rtl/asw_bias_out.sv
module asw_bias_out #(
  parameter int SUM_W = 11,
  parameter int ACT_W = 10,
  parameter int BIAS  = 2,
  parameter int OUT_W = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     done,
  input  logic                     tern,
  input  logic signed [SUM_W-1:0]  sum_in,
  input  logic [ACT_W-1:0]         act_sum,
  output logic                     res_valid,
  output logic signed [OUT_W-1:0]  res_data
);
  localparam logic signed [OUT_W-1:0] BIAS_V = OUT_W'(BIAS);

  logic signed [OUT_W-1:0] sum_ext;
  logic signed [OUT_W-1:0] act_ext;
  logic signed [OUT_W-1:0] bias_term;
  logic signed [OUT_W-1:0] add_c;

  assign sum_ext   = OUT_W'(sum_in);
  assign act_ext   = $signed({{(OUT_W-ACT_W){1'b0}}, act_sum});
  assign bias_term = act_ext * BIAS_V;
  assign add_c     = tern ? '0 : bias_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= done;
      if (done) res_data <= sum_ext + add_c;
    end
  end

  a_r6_tern_passthru: assert property (@(posedge clk) disable iff (rst)
    (done && tern) |=> (res_data == $past(sum_ext)));
  a_r7_valid_follows_done: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(done));
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(res_data));

endmodule

// File: rtl/asw_codec_top.sv
module asw_codec_top #(
  parameter int WIN_W  = 5,
  parameter int NPAIR  = 2,
  parameter int PAIR_W = 8,
  parameter int ACT_W  = 10,
  parameter int BIAS   = 2,
  localparam int CODE_W = 2 * NPAIR,
  localparam int SUM_W  = PAIR_W + 2 * (NPAIR - 1) + 1,
  localparam int BIAS_W = $clog2(BIAS + 1),
  localparam int OUT_W  = ((SUM_W > ACT_W + BIAS_W + 1) ? SUM_W : ACT_W + BIAS_W + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enc_in_valid,
  input  logic signed [WIN_W-1:0]  enc_weight,
  output logic                     enc_out_valid,
  output logic [CODE_W-1:0]        enc_code,
  output logic                     enc_err,
  input  logic                     pair_valid,
  input  logic signed [PAIR_W-1:0] pair_data,
  input  logic [ACT_W-1:0]         act_sum,
  input  logic                     ternary_mode,
  output logic                     res_valid,
  output logic signed [OUT_W-1:0]  res_data
);
  logic                    grp_done;
  logic                    grp_tern;
  logic signed [SUM_W-1:0] grp_sum;

  asw_encoder #(.WIN_W(WIN_W), .NPAIR(NPAIR), .BIAS(BIAS)) u_enc (
    .clk(clk), .rst(rst), .in_valid(enc_in_valid), .weight(enc_weight),
    .out_valid(enc_out_valid), .code(enc_code), .err(enc_err)
  );

  asw_pair_acc #(.PAIR_W(PAIR_W), .NPAIR(NPAIR), .SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst(rst), .pair_valid(pair_valid), .pair_data(pair_data),
    .ternary_mode(ternary_mode), .done(grp_done), .tern(grp_tern), .sum(grp_sum)
  );

  asw_bias_out #(.SUM_W(SUM_W), .ACT_W(ACT_W), .BIAS(BIAS), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst(rst), .done(grp_done), .tern(grp_tern), .sum_in(grp_sum),
    .act_sum(act_sum), .res_valid(res_valid), .res_data(res_data)
  );

  a_r7_res_needs_beat: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(pair_valid));
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!res_valid && !enc_out_valid));

endmodule

// File: tb/asw_codec_top_tb_top.sv
`timescale 1ns/1ps
module asw_codec_top_tb_top;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              enc_in_valid = 1'b0;
  logic signed [4:0] enc_weight = '0;
  logic              enc_out_valid;
  logic [3:0]        enc_code;
  logic              enc_err;
  logic              pair_valid = 1'b0;
  logic signed [7:0] pair_data = '0;
  logic [9:0]        act_sum = '0;
  logic              ternary_mode = 1'b0;
  logic              res_valid;
  logic signed [13:0] res_data;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  asw_codec_top dut_i (
    .clk(clk), .rst(rst), .enc_in_valid(enc_in_valid), .enc_weight(enc_weight),
    .enc_out_valid(enc_out_valid), .enc_code(enc_code), .enc_err(enc_err),
    .pair_valid(pair_valid), .pair_data(pair_data), .act_sum(act_sum),
    .ternary_mode(ternary_mode), .res_valid(res_valid), .res_data(res_data)
  );

  // Each entry: weights w3..w0 (signed nibbles) then activations x3..x0.
  localparam int NVEC = 8;
  localparam logic [31:0] VEC_TABLE [NVEC] = '{
    32'h0000_0000, 32'h7777_FFFF, 32'h8888_FFFF, 32'h1234_5678,
    32'hF8E9_A3C1, 32'h2222_9999, 32'h7F80_0F0F, 32'hC5A3_1E2D
  };

  task automatic check(input string req, input longint got, input longint exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Code whose alternating-sign value equals w - 2 (R1 encoding).
  function automatic logic [3:0] ref_code(input int w);
    for (int c = 0; c < 16; c++) begin
      if (-8 * ((c >> 3) & 1) + 4 * ((c >> 2) & 1) - 2 * ((c >> 1) & 1) + (c & 1) == w - 2)
        return 4'(c);
    end
    return 4'h0;
  endfunction

  task automatic enc_check(input int w, input string req);
    enc_in_valid = 1'b1;
    enc_weight   = 5'(w);
    @(negedge clk);
    enc_in_valid = 1'b0;
    check({req, " enc_out_valid"}, enc_out_valid, 1);
    if (w >= -8 && w <= 7) begin
      check({req, " enc_code"}, enc_code, ref_code(w));
      check({req, " enc_err"}, enc_err, 0);
    end else begin
      check({req, " R2 err"}, enc_err, 1);
      check({req, " R2 code"}, enc_code, 0);
    end
  endtask

  task automatic beat(input int p, input int act, input bit mode);
    pair_valid   = 1'b1;
    pair_data    = 8'(p);
    act_sum      = 10'(act);
    ternary_mode = mode;
    @(negedge clk);
    pair_valid   = 1'b0;
    ternary_mode = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 res_valid in reset", res_valid, 0);
    check("R9 res_data in reset", res_data, 0);
    check("R9 enc_out_valid in reset", enc_out_valid, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1, R4, R5: table walk, reference is the plain dot product
    for (int v = 0; v < NVEC; v++) begin
      int w [4];
      int x [4];
      int col [4];
      int xs;
      int dot;
      logic [3:0] cd;
      xs = 0;
      dot = 0;
      for (int k = 0; k < 4; k++) col[k] = 0;
      for (int i = 0; i < 4; i++) begin
        int nib;
        nib  = int'(VEC_TABLE[v][16 + 4*i +: 4]);
        w[i] = (nib >= 8) ? nib - 16 : nib;
        x[i] = int'(VEC_TABLE[v][4*i +: 4]);
        enc_check(w[i], "R1 table");
        cd = ref_code(w[i]);
        for (int k = 0; k < 4; k++) col[k] += x[i] * int'(cd[k]);
        xs  += x[i];
        dot += w[i] * x[i];
      end
      beat(col[0] - 2 * col[1], 1023 - xs, 1'b0);  // act_sum here must be ignored (R5)
      check("R7 no result after lower beat", res_valid, 0);
      beat(col[2] - 2 * col[3], xs, 1'b0);
      check("R4 res_valid", res_valid, 1);
      check("R4 R5 dot product", res_data, dot);
    end

    // R2: every out-of-range weight; R3: valid drops with no input
    for (int w = -16; w < 16; w++) if (w < -8 || w > 7) enc_check(w, "R2 range");
    @(negedge clk);
    check("R3 enc_out_valid idle", enc_out_valid, 0);
    enc_check(-8, "R1 low edge");
    enc_check(7, "R1 high edge");

    // R6: ternary pass-through, bias not added
    beat(-128, 500, 1'b1);
    check("R6 ternary valid", res_valid, 1);
    check("R6 ternary data", res_data, -128);
    beat(77, 1000, 1'b1);
    check("R6 ternary data pos", res_data, 77);
    @(negedge clk);
    check("R7 pulse single", res_valid, 0);

    // R6: mode ignored on upper beat
    beat(5, 0, 1'b0);
    beat(3, 7, 1'b1);
    check("R6 mode ignored upper", res_data, 5 + 12 + 14);

    // R7: gaps between beats
    beat(-9, 0, 1'b0);
    for (int g = 0; g < 3; g++) begin
      check("R7 no valid in gap", res_valid, 0);
      @(negedge clk);
    end
    beat(-2, 11, 1'b0);
    check("R7 valid after gap", res_valid, 1);
    check("R7 gap result", res_data, -9 - 8 + 22);

    // R8: extremes
    beat(127, 0, 1'b0);
    beat(127, 1023, 1'b0);
    check("R8 max", res_data, 2681);
    beat(-128, 1023, 1'b0);
    beat(-128, 0, 1'b0);
    check("R8 min", res_data, -640);

    // R9: reset mid-group drops the partial group
    beat(100, 0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset clears valid", res_valid, 0);
    check("R9 reset clears data", res_data, 0);
    beat(10, 0, 1'b0);
    check("R9 new lower beat", res_valid, 0);
    beat(20, 0, 1'b0);
    check("R9 regrouped result", res_data, 90);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule